// File: doc/BRIEF.md
# Two-Wire GPIO Expander Register Slave

This block gives a host on a two-wire serial bus (I2C) control over eight general-purpose pins. It runs from a fast system clock, oversamples the bus clock and data lines, and takes part in the bus only through an open-drain pull-down on the data line. The block holds three writable bytes: the level driven on each pin, a direction mask and a read-back inversion mask. A fourth, read-only byte returns the live pin levels.

A transaction opens with a START condition and an address byte. The slave address is `0100` followed by the three strap inputs. In a write, the first byte after the address is a command byte that selects the register. Any further bytes in that transaction are data for the selected register. For a read, the host first writes the command byte, then issues a repeated START with the read bit set and clocks data bytes out until it declines to acknowledge one. The register pointer never advances on its own.

Top module: `i2c_gpio_expander`

## Requirements
- R1: After reset the output byte is 0xFF, the inversion mask is 0x00 and the direction byte is 0xFF, so every pin is undriven (`pin_oe` = 0x00, `pin_o` = 0xFF).
- R2: An address byte whose upper seven bits equal `0100` followed by `addr_strap[2:0]` is acknowledged. The block holds SDA low for the whole high phase of the ninth clock pulse.
- R3: An address that does not match receives no acknowledge. All following bytes are then ignored, with no acknowledge and no register change, until the next START or STOP.
- R4: In a write transaction, the command byte and every data byte are acknowledged.
- R5: Bits [1:0] of the command byte select the register: 0 = input levels, 1 = output byte, 2 = inversion mask, 3 = direction byte. Writes to selections 1 to 3 update that register, and reads return it.
- R6: A write that targets selection 0 is acknowledged but changes no register.
- R7: Reading selection 0 returns the live level of each pin XOR the inversion mask. This holds whether the pin is driven by the block or by outside logic.
- R8: Read bytes are shifted out MSB first. SDA is released on the ninth clock. When the master acknowledges, the next byte follows.
- R9: When the master does not acknowledge a read byte, the block never pulls SDA low again until a STOP. After the STOP it serves new transactions normally.
- R10: A direction bit of 0 drives that pin from the matching output bit (`pin_oe`=1, `pin_o`=output bit). A direction bit of 1 leaves the pin undriven.
- R11: The pointer does not auto-increment. Several data bytes in one write all land in the same register, and a repeated START keeps the pointer for the read that follows.
- R12: The block starts pulling SDA low only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| sda_oe | output | 1 | 1 = pull SDA low |
| addr_strap | input | 3 | Low three bits of the slave address |
| pin_i | input | 8 | Sensed pin levels |
| pin_o | output | 8 | Level driven on each pin |
| pin_oe | output | 8 | Per-pin driver enable |

## Verification
The bench sweeps all 128 addresses against a fixed strap value. A decoder that compared the wrong bits, or that ignored the straps, would acknowledge extra addresses or miss the right one. It crosses direction, output, external-level and inversion patterns, so a read-back that reported the output register instead of the real pin level, or that applied the inversion on the wrong side, gives a wrong byte. It reads an asymmetric value across several acknowledged bytes, which exposes bit-order reversal and pointer auto-increment. After a master NACK it clocks on with the output byte at zero, so a slave that kept transmitting would pull SDA low where the bus should read all ones.

// File: rtl/xp_pkg.sv
package xp_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 4;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_WDAT,
    ST_ACK,
    ST_RDAT,
    ST_RACK,
    ST_HOLD
  } xp_state_e;

  localparam logic [1:0] SEL_IN  = 2'd0;
  localparam logic [1:0] SEL_OUT = 2'd1;
  localparam logic [1:0] SEL_POL = 2'd2;
  localparam logic [1:0] SEL_DIR = 2'd3;
endpackage

// File: rtl/xp_line_sync.sv
module xp_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_prev, sda_prev;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            scl_sh[0] <= 1'b1;
            sda_sh[0] <= 1'b1;
          end else begin
            scl_sh[0] <= scl_i;
            sda_sh[0] <= sda_i;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            scl_sh[s] <= 1'b1;
            sda_sh[s] <= 1'b1;
          end else begin
            scl_sh[s] <= scl_sh[s-1];
            sda_sh[s] <= sda_sh[s-1];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_sh[STAGES-1];
      sda_prev <= sda_sh[STAGES-1];
    end
  end

  assign scl_lvl   = scl_sh[STAGES-1];
  assign sda_lvl   = sda_sh[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/xp_protocol.sv
module xp_protocol
  import xp_pkg::*;
#(
  parameter logic [3:0] ADDR_FIXED = 4'b0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_lvl,
  input  logic [2:0]        strap,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_pull,
  output logic [1:0]        ptr,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_data,
  output xp_state_e         state_o
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  xp_state_e         st_q, st_d, ret_q, ret_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d, wd_q, wd_d;
  logic              sda_q, sda_d, mack_q, mack_d, we_q, we_d;
  logic [1:0]        ptr_q, ptr_d;

  always_comb begin
    st_d   = st_q;
    ret_d  = ret_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    wd_d   = wd_q;
    sda_d  = sda_q;
    mack_d = mack_q;
    ptr_d  = ptr_q;
    we_d   = 1'b0;
    if (stop_det) begin
      st_d  = ST_IDLE;
      sda_d = 1'b0;
    end else if (start_det) begin
      st_d  = ST_ADDR;
      cnt_d = '0;
      sda_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_ADDR, ST_CMD, ST_WDAT: begin
          if (scl_rise && cnt_q != LAST_BIT) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_lvl};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == LAST_BIT) begin
            cnt_d = '0;
            if (st_q == ST_ADDR) begin
              if (sh_q[BYTE_W-1:1] == {ADDR_FIXED, strap}) begin
                st_d  = ST_ACK;
                sda_d = 1'b1;
                ret_d = sh_q[0] ? ST_RDAT : ST_CMD;
              end else begin
                st_d = ST_HOLD;
              end
            end else if (st_q == ST_CMD) begin
              ptr_d = sh_q[1:0];
              st_d  = ST_ACK;
              sda_d = 1'b1;
              ret_d = ST_WDAT;
            end else begin
              we_d  = 1'b1;
              wd_d  = sh_q;
              st_d  = ST_ACK;
              sda_d = 1'b1;
              ret_d = ST_WDAT;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (ret_q == ST_RDAT) begin
              st_d  = ST_RDAT;
              sh_d  = rd_data;
              sda_d = ~rd_data[BYTE_W-1];
            end else begin
              st_d  = ret_q;
              sda_d = 1'b0;
            end
          end
        end
        ST_RDAT: begin
          if (scl_rise) begin
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall) begin
            if (cnt_q == LAST_BIT) begin
              st_d  = ST_RACK;
              sda_d = 1'b0;
            end else begin
              sh_d  = {sh_q[BYTE_W-2:0], 1'b0};
              sda_d = ~sh_q[BYTE_W-2];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack_d = ~sda_lvl;
          end else if (scl_fall) begin
            cnt_d = '0;
            if (mack_q) begin
              st_d  = ST_RDAT;
              sh_d  = rd_data;
              sda_d = ~rd_data[BYTE_W-1];
            end else begin
              st_d = ST_HOLD;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ret_q  <= ST_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      wd_q   <= '0;
      sda_q  <= 1'b0;
      mack_q <= 1'b0;
      ptr_q  <= SEL_IN;
      we_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      ret_q  <= ret_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      wd_q   <= wd_d;
      sda_q  <= sda_d;
      mack_q <= mack_d;
      ptr_q  <= ptr_d;
      we_q   <= we_d;
    end
  end

  assign sda_pull = sda_q;
  assign ptr      = ptr_q;
  assign wr_en    = we_q;
  assign wr_data  = wd_q;
  assign state_o  = st_q;
endmodule

// File: rtl/xp_regfile.sv
module xp_regfile
  import xp_pkg::*;
#(
  parameter int PIN_SYNC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] pin_i,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] pin_sync,
  output logic [BYTE_W-1:0] out_q,
  output logic [BYTE_W-1:0] pol_q,
  output logic [BYTE_W-1:0] dir_q
);
  logic [BYTE_W-1:0] sync_q [PIN_SYNC];
  logic en_out, en_pol, en_dir;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PIN_SYNC; i++) sync_q[i] <= '0;
    end else begin
      sync_q[0] <= pin_i;
      for (int i = 1; i < PIN_SYNC; i++) sync_q[i] <= sync_q[i-1];
    end
  end
  assign pin_sync = sync_q[PIN_SYNC-1];

  assign en_out = wr_en && (wr_sel == SEL_OUT);
  assign en_pol = wr_en && (wr_sel == SEL_POL);
  assign en_dir = wr_en && (wr_sel == SEL_DIR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '1;
      pol_q <= '0;
      dir_q <= '1;
    end else begin
      if (en_out) out_q <= wr_data;
      if (en_pol) pol_q <= wr_data;
      if (en_dir) dir_q <= wr_data;
    end
  end
endmodule

// File: rtl/i2c_gpio_expander.sv
module i2c_gpio_expander
  import xp_pkg::*;
#(
  parameter logic [3:0] ADDR_FIXED  = 4'b0100,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [2:0]        addr_strap,
  input  logic [BYTE_W-1:0] pin_i,
  output logic [BYTE_W-1:0] pin_o,
  output logic [BYTE_W-1:0] pin_oe
);
  logic [1:0] rst_sh;
  logic rst_n_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh <= 2'b00;
    else        rst_sh <= {rst_sh[0], 1'b1};
  end
  assign rst_n_sync = rst_sh[1];

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en;
  logic [1:0] ptr;
  logic [BYTE_W-1:0] wr_data, rd_data, pin_sync, out_w, pol_w, dir_w;
  xp_state_e proto_state;

  xp_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n_sync), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  xp_protocol #(.ADDR_FIXED(ADDR_FIXED)) u_proto (
    .clk(clk), .rst_n(rst_n_sync), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_lvl(sda_lvl),
    .strap(addr_strap), .rd_data(rd_data), .sda_pull(sda_oe), .ptr(ptr),
    .wr_en(wr_en), .wr_data(wr_data), .state_o(proto_state)
  );

  xp_regfile #(.PIN_SYNC(SYNC_STAGES)) u_regs (
    .clk(clk), .rst_n(rst_n_sync), .pin_i(pin_i), .wr_en(wr_en),
    .wr_sel(ptr), .wr_data(wr_data), .pin_sync(pin_sync),
    .out_q(out_w), .pol_q(pol_w), .dir_q(dir_w)
  );

  always_comb begin
    unique case (ptr)
      SEL_IN:  rd_data = pin_sync ^ pol_w;
      SEL_OUT: rd_data = out_w;
      SEL_POL: rd_data = pol_w;
      default: rd_data = dir_w;
    endcase
  end

  generate
    for (genvar k = 0; k < BYTE_W; k++) begin : g_pin
      assign pin_o[k]  = out_w[k];
      assign pin_oe[k] = ~dir_w[k];
    end
  endgenerate
endmodule

// File: rtl/xp_checker.sv
module xp_checker
  import xp_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              scl_lvl,
  input logic              sda_pull,
  input logic              wr_en,
  input logic [1:0]        wr_sel,
  input logic [BYTE_W-1:0] out_q,
  input logic [BYTE_W-1:0] pol_q,
  input logic [BYTE_W-1:0] dir_q,
  input xp_state_e         state
);
  assert_pull_while_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !$past(scl_lvl));

  assert_input_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && wr_sel == SEL_IN) |-> ($stable(out_q) && $stable(pol_q) && $stable(dir_q)));

  assert_pol_changes_only_on_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pol_q) |-> ($past(wr_en) && $past(wr_sel) == SEL_POL));

  assert_silent_after_nack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD) |-> !sda_pull);

  assert_pull_only_ack_or_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull |-> (state == ST_ACK || state == ST_RDAT));
endmodule

bind i2c_gpio_expander xp_checker chk_i (
  .clk(clk), .rst_n(rst_n_sync), .scl_lvl(scl_lvl), .sda_pull(sda_oe),
  .wr_en(wr_en), .wr_sel(ptr), .out_q(out_w), .pol_q(pol_w), .dir_q(dir_w),
  .state(proto_state)
);

// File: tb/i2c_gpio_expander_tb_top.sv
`timescale 1ns/1ps
module i2c_gpio_expander_tb_top;
  localparam int HALF = 12;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] strap = STRAP;
  logic [7:0] ext = 8'h00;
  logic sda_oe;
  logic [7:0] pin_o, pin_oe, pin_lvl;
  wire sda_line = sda_m & ~sda_oe;
  int total = 0, bad = 0, r12_viol = 0;
  logic prev_oe = 1'b0;

  always #5 clk = ~clk;

  assign pin_lvl = (pin_oe & pin_o) | (~pin_oe & ext);

  i2c_gpio_expander dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_strap(strap), .pin_i(pin_lvl), .pin_o(pin_o), .pin_oe(pin_oe)
  );

  always @(negedge clk) begin
    if (sda_oe && !prev_oe && scl_m) r12_viol++;
    prev_oe <= sda_oe;
  end

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=expired exp=done");
    finish_run();
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    w(4); sda_m = 1'b1; w(HALF); scl_m = 1'b1; w(HALF); sda_m = 1'b0; w(HALF); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    w(4); sda_m = 1'b0; w(HALF); scl_m = 1'b1; w(HALF); sda_m = 1'b1; w(HALF);
  endtask

  task automatic bit_clk(input logic b);
    w(4); sda_m = b; w(HALF - 4); scl_m = 1'b1; w(HALF); scl_m = 1'b0;
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic acked);
    logic early, late;
    for (int i = 7; i >= 0; i--) bit_clk(b[i]);
    w(4); sda_m = 1'b1; w(HALF - 4); scl_m = 1'b1;
    w(2); early = sda_line; w(HALF - 3); late = sda_line; w(1); scl_m = 1'b0;
    acked = !early && !late;
  endtask

  task automatic rd_byte(input logic give_ack, output logic [7:0] d);
    w(1); sda_m = 1'b1;
    d = 8'h00;
    for (int i = 0; i < 8; i++) begin
      w(HALF - 1); scl_m = 1'b1; w(HALF / 2); d = {d[6:0], sda_line}; w(HALF / 2); scl_m = 1'b0;
      w(1) ;
    end
    bit_clk(!give_ack);
  endtask

  localparam logic [6:0] MY_ADDR = {4'b0100, STRAP};

  task automatic wr_reg(input logic [1:0] sel, input logic [7:0] v, input string req);
    logic a0, a1, a2;
    bus_start(); wr_byte({MY_ADDR, 1'b0}, a0); wr_byte({6'd0, sel}, a1); wr_byte(v, a2); bus_stop();
    chk(a0 && a1 && a2, req, {29'd0, a0, a1, a2}, 32'h7);
  endtask

  task automatic rd_reg(input logic [1:0] sel, output logic [7:0] d);
    logic a0, a1, a2;
    bus_start(); wr_byte({MY_ADDR, 1'b0}, a0); wr_byte({6'd0, sel}, a1);
    bus_start(); wr_byte({MY_ADDR, 1'b1}, a2); rd_byte(1'b0, d); bus_stop();
    if (!(a0 && a1 && a2)) d = 8'hxx;
  endtask

  initial begin
    logic [7:0] d, d1, d2, lvl;
    logic ack, a1, a2;
    logic [7:0] dirs [5] = '{8'h00, 8'h0F, 8'hF0, 8'h5A, 8'hFF};
    logic [7:0] outs [5] = '{8'h3C, 8'hA5, 8'h01, 8'hFE, 8'h69};
    logic [7:0] exts [5] = '{8'h00, 8'hFF, 8'h3C, 8'hC3, 8'h81};
    logic [7:0] pols [3] = '{8'h00, 8'hF0, 8'h55};

    w(5); rst_n = 1'b1; w(10);
    // R1 reset state
    chk(pin_oe === 8'h00, "R1 pin_oe", {24'd0, pin_oe}, 32'h00);
    chk(pin_o === 8'hFF, "R1 pin_o", {24'd0, pin_o}, 32'hFF);
    chk(sda_oe === 1'b0, "R1 sda_oe", {31'd0, sda_oe}, 0);
    rd_reg(2'd1, d); chk(d === 8'hFF, "R1 out", {24'd0, d}, 32'hFF);
    rd_reg(2'd2, d); chk(d === 8'h00, "R1 pol", {24'd0, d}, 32'h00);
    rd_reg(2'd3, d); chk(d === 8'hFF, "R1 dir", {24'd0, d}, 32'hFF);

    // R2 / R3 address sweep
    for (int a = 0; a < 128; a++) begin
      bus_start(); wr_byte({a[6:0], 1'b0}, ack); bus_stop();
      if (a[6:0] == MY_ADDR) chk(ack, "R2 match ack", {31'd0, ack}, 1);
      else chk(!ack, "R3 mismatch ack", {25'd0, a[6:0]}, 0);
    end
    strap = 3'b010; w(10);
    bus_start(); wr_byte({7'h22, 1'b0}, ack); bus_stop();
    chk(ack, "R2 strap change ack", {31'd0, ack}, 1);
    bus_start(); wr_byte({MY_ADDR, 1'b0}, ack); bus_stop();
    chk(!ack, "R3 old strap ack", {31'd0, ack}, 0);
    strap = STRAP; w(10);

    // R3 bytes after mismatch are ignored
    bus_start(); wr_byte(8'h60, ack); wr_byte(8'h01, a1); wr_byte(8'h00, a2); bus_stop();
    chk(!ack && !a1 && !a2, "R3 trailing ack", {29'd0, ack, a1, a2}, 0);
    rd_reg(2'd1, d); chk(d === 8'hFF, "R3 out untouched", {24'd0, d}, 32'hFF);

    // R4 R5 R10 sweep of direction and output
    for (int i = 0; i < 5; i++) begin
      wr_reg(2'd3, dirs[i], "R4 dir write ack");
      wr_reg(2'd1, outs[i], "R4 out write ack");
      w(4);
      chk(pin_oe === ~dirs[i], "R10 pin_oe", {24'd0, pin_oe}, {24'd0, ~dirs[i]});
      chk(pin_o === outs[i], "R10 pin_o", {24'd0, pin_o}, {24'd0, outs[i]});
      rd_reg(2'd3, d); chk(d === dirs[i], "R5 dir read", {24'd0, d}, {24'd0, dirs[i]});
      rd_reg(2'd1, d); chk(d === outs[i], "R5 out read", {24'd0, d}, {24'd0, outs[i]});
    end
    wr_reg(2'd2, 8'hC6, "R4 pol write ack");
    rd_reg(2'd2, d); chk(d === 8'hC6, "R5 pol read", {24'd0, d}, 32'hC6);

    // R6 write to input selection ignored
    wr_reg(2'd0, 8'h3C, "R6 input write ack");
    rd_reg(2'd1, d); chk(d === 8'h69, "R6 out kept", {24'd0, d}, 32'h69);
    rd_reg(2'd2, d); chk(d === 8'hC6, "R6 pol kept", {24'd0, d}, 32'hC6);
    rd_reg(2'd3, d); chk(d === 8'hFF, "R6 dir kept", {24'd0, d}, 32'hFF);

    // R7 input read-back with mixed directions
    wr_reg(2'd3, 8'h0F, "R4 dir write ack");
    wr_reg(2'd1, 8'hA5, "R4 out write ack");
    for (int p = 0; p < 3; p++) begin
      wr_reg(2'd2, pols[p], "R4 pol write ack");
      for (int e = 0; e < 5; e++) begin
        ext = exts[e]; w(6);
        lvl = (8'hF0 & 8'hA5) | (8'h0F & exts[e]);
        rd_reg(2'd0, d);
        chk(d === (lvl ^ pols[p]), "R7 input read", {24'd0, d}, {24'd0, lvl ^ pols[p]});
      end
    end
    wr_reg(2'd2, 8'h00, "R4 pol write ack");

    // R8 multi-byte read, MSB first, continue on ACK
    wr_reg(2'd1, 8'h96, "R4 out write ack");
    bus_start(); wr_byte({MY_ADDR, 1'b0}, ack); wr_byte(8'h01, a1);
    bus_start(); wr_byte({MY_ADDR, 1'b1}, a2);
    rd_byte(1'b1, d); rd_byte(1'b1, d1); rd_byte(1'b0, d2); bus_stop();
    chk(d === 8'h96 && d1 === 8'h96 && d2 === 8'h96, "R8 repeated read",
        {8'd0, d, d1, d2}, 32'h00969696);

    // R9 silence after NACK
    wr_reg(2'd1, 8'h00, "R4 out write ack");
    bus_start(); wr_byte({MY_ADDR, 1'b0}, ack); wr_byte(8'h01, a1);
    bus_start(); wr_byte({MY_ADDR, 1'b1}, a2);
    rd_byte(1'b0, d);
    chk(d === 8'h00, "R9 first byte", {24'd0, d}, 0);
    rd_byte(1'b0, d1);
    chk(d1 === 8'hFF, "R9 quiet after nack", {24'd0, d1}, 32'hFF);
    bus_stop();
    rd_reg(2'd1, d); chk(d === 8'h00, "R9 recovers after stop", {24'd0, d}, 0);

    // R11 no auto-increment on writes, pointer kept over repeated START
    bus_start(); wr_byte({MY_ADDR, 1'b0}, ack); wr_byte(8'h01, a1);
    wr_byte(8'h11, a2); wr_byte(8'h22, a2); bus_stop();
    rd_reg(2'd1, d); chk(d === 8'h22, "R11 same register", {24'd0, d}, 32'h22);
    rd_reg(2'd2, d); chk(d === 8'h00, "R11 neighbour untouched", {24'd0, d}, 0);
    wr_reg(2'd2, 8'h5B, "R4 pol write ack");
    bus_start(); wr_byte({MY_ADDR, 1'b0}, ack); wr_byte(8'h02, a1);
    bus_start(); wr_byte({MY_ADDR, 1'b1}, a2); rd_byte(1'b0, d); bus_stop();
    chk(d === 8'h5B, "R11 pointer after rstart", {24'd0, d}, 32'h5B);

    // R12 pull-down only begins with SCL low
    chk(r12_viol == 0, "R12 pull on high", r12_viol, 0);

    finish_run();
  end
endmodule